// File: doc/BRIEF.md
# Polled I2C Register Target

This block is an I2C target that runs entirely on the system clock. Both bus lines are oversampled through a synchronizer, and bus edges, start conditions and stop conditions are all found on the synchronized copies. Incoming bytes are shifted in MSB first. The target answers its 7-bit address, which is a fixed 4-bit prefix followed by three strap pins, and it drives the acknowledge bit. It returns read data MSB first, changing each bit just after an SCL falling edge.

Behind the target sits a register bank. The first byte after the address in a write transfer sets a register pointer. Every later byte in that transfer is written to that same pointer, and the pointer never advances. A read transfer streams the byte at the current pointer. To read a chosen register, the host writes the pointer, issues a repeated start, then reads.

The bank can raise a busy input while it commits settings to nonvolatile storage. While busy is high, the target refuses its own address, so the host can keep polling until it is acknowledged. Each transfer ends with a one-cycle stop or repeated-start event. That event carries a flag that tells the bank whether the transfer wrote a register, which tells the bank when to begin a commit.

Top module: `i2c_poll_target`

## Requirements
- R1: The target acknowledges (drives SDA low during the ninth clock) an address byte whose upper seven bits equal binary 1010 followed by strap_i[2], strap_i[1], strap_i[0]. Bit 0 of the address byte selects the direction: 0 = write, 1 = read.
- R2: An address byte that does not match gets no acknowledge. All following bytes are ignored, with no SDA drive and no write strobe, until the next start condition.
- R3: If busy_i is high when the last address bit is sampled, the address is not acknowledged, even when it matches.
- R4: In a write transfer, the byte after the address is acknowledged and loaded into reg_ptr_o.
- R5: Each further byte of a write transfer is acknowledged and produces a one-cycle wr_strobe_o with that byte on wr_data_o at the unchanged reg_ptr_o. The pointer does not increment.
- R6: A read transfer returns rd_data_i at the current pointer, MSB first. Repeated bytes read the same pointer.
- R7: After the host NACKs a read byte, the target releases SDA and leaves it released until the next start.
- R8: stop_o pulses for one cycle on a stop, and rstart_o pulses for one cycle on a start, but only while the target is addressed. xfer_wrote_o is high with that pulse exactly when the transfer contained at least one register write.
- R9: A start or stop in the middle of a byte drops the partial byte, with no write strobe, and returns the target to address reception.
- R10: After reset, SDA is released, reg_ptr_o is 0, and no strobe or event output is high.
- R11: The SDA drive changes only while SCL is low, except when a start or stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_i | input | 3 | Low address bits from strap pins |
| busy_i | input | 1 | Register bank busy committing; address is refused |
| reg_ptr_o | output | 8 | Current register pointer |
| wr_strobe_o | output | 1 | One-cycle register write strobe |
| wr_data_o | output | 8 | Write data, valid with the strobe |
| rd_data_i | input | 8 | Register bank data at reg_ptr_o |
| stop_o | output | 1 | One-cycle stop event for an addressed transfer |
| rstart_o | output | 1 | One-cycle repeated-start event for an addressed transfer |
| xfer_wrote_o | output | 1 | With stop_o or rstart_o: the transfer wrote a register |

## Verification
The assertions watch several properties on every cycle. They check that the SDA drive never moves while SCL is high, except when a bus condition occurs. They check that any start sends the target back to address reception, that a busy address phase always ends idle, that write strobes occur only while the target is addressed, and that the two event pulses never coincide. Other behaviour can only be shown by the bench's scenarios: the acknowledge pattern seen on the line, the byte values returned by reads, the fact that the pointer does not advance, silence after a wrong address, and the write flag attached to each event. The bench's host tasks drive whole transfers for these, both directed and randomized.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= scl_i;
          sda_sync <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // bus conditions only while SCL stays high
  assign start_o    = scl_o & scl_q & ~sda_o & sda_q;
  assign stop_o     = scl_o & scl_q & sda_o & ~sda_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_tgt_pkg::*;
#(
  parameter int                      STRAP_W  = 3,
  parameter logic [6-STRAP_W:0]      PREFIX   = 4'b1010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  reg_ptr_o,
  output logic               wr_strobe_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               stop_o,
  output logic               rstart_o,
  output logic               xfer_wrote_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  tgt_state_e          state_q;
  byte_kind_e          kind_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   rx_sr_q, tx_sr_q;
  logic                sel_q, rw_q, wrote_q;
  logic [BYTE_W-1:0]   rx_byte;
  logic                addr_hit;

  assign rx_byte  = {rx_sr_q[BYTE_W-2:0], sda_i};
  assign addr_hit = (rx_byte[BYTE_W-1:1] == {PREFIX, strap_i}) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      kind_q       <= K_ADDR;
      cnt_q        <= '0;
      rx_sr_q      <= '0;
      tx_sr_q      <= '1;
      sel_q        <= 1'b0;
      rw_q         <= 1'b0;
      wrote_q      <= 1'b0;
      reg_ptr_o    <= '0;
      wr_strobe_o  <= 1'b0;
      wr_data_o    <= '0;
      stop_o       <= 1'b0;
      rstart_o     <= 1'b0;
      xfer_wrote_o <= 1'b0;
    end else begin
      wr_strobe_o  <= 1'b0;
      stop_o       <= 1'b0;
      rstart_o     <= 1'b0;
      xfer_wrote_o <= 1'b0;
      if (start_i) begin
        rstart_o     <= sel_q;
        xfer_wrote_o <= sel_q & wrote_q;
        sel_q        <= 1'b0;
        wrote_q      <= 1'b0;
        state_q      <= ST_RX;
        kind_q       <= K_ADDR;
        cnt_q        <= '0;
      end else if (stop_i) begin
        stop_o       <= sel_q;
        xfer_wrote_o <= sel_q & wrote_q;
        sel_q        <= 1'b0;
        wrote_q      <= 1'b0;
        state_q      <= ST_IDLE;
        cnt_q        <= '0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != FULL) begin
              rx_sr_q <= rx_byte;
              cnt_q   <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) begin
                unique case (kind_q)
                  K_ADDR: begin
                    if (addr_hit) begin
                      sel_q <= 1'b1;
                      rw_q  <= rx_byte[0];
                    end else begin
                      state_q <= ST_IDLE;
                    end
                  end
                  K_PTR: reg_ptr_o <= rx_byte;
                  default: begin
                    wr_strobe_o <= 1'b1;
                    wr_data_o   <= rx_byte;
                    wrote_q     <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall_i && cnt_q == FULL) begin
              state_q <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (kind_q == K_ADDR && rw_q) begin
                state_q <= ST_TX;
                tx_sr_q <= rd_data_i;
              end else begin
                state_q <= ST_RX;
                kind_q  <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == FULL) state_q <= ST_TXACK;
              else               tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b1};
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) begin
              if (sda_i) state_q <= ST_IDLE;  // host NACK ends the read
            end else if (scl_fall_i) begin
              state_q <= ST_TX;
              tx_sr_q <= rd_data_i;
              cnt_q   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (state_q == ST_ACK) || (state_q == ST_TX && !tx_sr_q[BYTE_W-1]);

  AST_BUSY_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX && kind_q == K_ADDR && cnt_q == LAST_BIT && scl_rise_i &&
     !start_i && !stop_i && busy_i) |=> (state_q == ST_IDLE));  // R3
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RX && kind_q == K_ADDR && cnt_q == '0));  // R9
  AST_STROBE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> sel_q);  // R5
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && rstart_o));  // R8
  AST_SDA_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_oe_o));  // R11
endmodule

// File: rtl/i2c_poll_target.sv
module i2c_poll_target
  import i2c_tgt_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter int                 STRAP_W     = 3,
  parameter logic [6-STRAP_W:0] PREFIX      = 4'b1010
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic [BYTE_W-1:0]  reg_ptr_o,
  output logic               wr_strobe_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               stop_o,
  output logic               rstart_o,
  output logic               xfer_wrote_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_byte_engine #(.STRAP_W(STRAP_W), .PREFIX(PREFIX)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_i        (scl_s),
    .sda_i        (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .strap_i      (strap_i),
    .busy_i       (busy_i),
    .sda_oe_o     (sda_oe_o),
    .reg_ptr_o    (reg_ptr_o),
    .wr_strobe_o  (wr_strobe_o),
    .wr_data_o    (wr_data_o),
    .rd_data_i    (rd_data_i),
    .stop_o       (stop_o),
    .rstart_o     (rstart_o),
    .xfer_wrote_o (xfer_wrote_o)
  );
endmodule

// File: tb/tb_i2c_poll_target.sv
module tb_i2c_poll_target;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       busy = 1'b0;
  logic       sda_oe;
  logic [7:0] reg_ptr, wr_data, rd_data;
  logic       wr_strobe, stop_p, rstart_p, xfer_wrote;
  wire        sda_line = sda_drv & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int checks = 0, failures = 0;
  int wr_cnt = 0, stop_cnt = 0, rs_cnt = 0, hold_err = 0;
  logic last_wrote = 1'b0;

  always #4 clk = ~clk;

  i2c_poll_target dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .busy_i(busy), .reg_ptr_o(reg_ptr),
    .wr_strobe_o(wr_strobe), .wr_data_o(wr_data), .rd_data_i(rd_data),
    .stop_o(stop_p), .rstart_o(rstart_p), .xfer_wrote_o(xfer_wrote)
  );

  assign rd_data = mem[reg_ptr];

  always @(negedge clk) begin
    if (wr_strobe) begin
      wr_cnt++;
      mem[reg_ptr] = wr_data;
    end
    if (stop_p)   begin stop_cnt++; last_wrote = xfer_wrote; end
    if (rstart_p) begin rs_cnt++;   last_wrote = xfer_wrote; end
  end

  function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q); scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; tick(Q); scl_drv = 1'b1; tick(2*Q); scl_drv = 1'b0; tick(Q);
  endtask

  task automatic read_bit(output logic b);
    logic s1;
    sda_drv = 1'b1; tick(Q); scl_drv = 1'b1; tick(Q);
    s1 = sda_line; tick(Q);
    b = sda_line;
    if (s1 != b) hold_err++;
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(a);
    ack = !a;
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
    send_bit(!host_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack, b;
    logic [7:0] v, p, d;
    int n0, s0, r0, dummy;
    dummy = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 29 + 7);
      exp_mem[i] = mem[i];
    end
    tick(5);
    rst_ni = 1'b1;
    tick(3);
    // R10 reset state
    chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
    chk(reg_ptr == 8'h00, "R10 pointer zero", reg_ptr, 0);
    chk(!wr_strobe && !stop_p && !rstart_p, "R10 no pulses", {wr_strobe, stop_p, rstart_p}, 0);

    // directed write: pointer then two bytes to same register
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    chk(ack, "R1 address ack", ack, 1);
    write_byte(8'h3C, ack);
    chk(ack, "R4 pointer ack", ack, 1);
    chk(reg_ptr == 8'h3C, "R4 pointer load", reg_ptr, 8'h3C);
    n0 = wr_cnt;
    write_byte(8'hA5, ack);
    exp_mem[8'h3C] = 8'hA5;
    chk(ack && wr_cnt == n0 + 1 && mem[8'h3C] == 8'hA5, "R5 first data", mem[8'h3C], 8'hA5);
    write_byte(8'h5A, ack);
    exp_mem[8'h3C] = 8'h5A;
    chk(ack && mem[8'h3C] == 8'h5A && reg_ptr == 8'h3C, "R5 overwrite same reg", mem[8'h3C], 8'h5A);
    chk(mem[8'h3D] == exp_mem[8'h3D], "R5 no increment", mem[8'h3D], exp_mem[8'h3D]);
    s0 = stop_cnt;
    bus_stop();
    chk(stop_cnt == s0 + 1 && last_wrote, "R8 stop with write flag", last_wrote, 1);

    // wrong address ignored
    bus_start();
    write_byte(addr_byte(3'b100, 1'b0), ack);
    chk(!ack, "R2 wrong address nack", ack, 0);
    n0 = wr_cnt;
    write_byte(8'h01, ack);
    write_byte(8'h77, ack);
    chk(!ack && wr_cnt == n0 && reg_ptr == 8'h3C, "R2 traffic ignored", wr_cnt, n0);
    s0 = stop_cnt;
    bus_stop();
    chk(stop_cnt == s0, "R8 no stop event unaddressed", stop_cnt, s0);

    // busy refuses address, then ready
    busy = 1'b1;
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    chk(!ack, "R3 busy nack", ack, 0);
    busy = 1'b0;
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    chk(ack, "R3 ack after busy", ack, 1);
    bus_stop();

    // pointer write, repeated start, read twice
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    write_byte(8'h10, ack);
    r0 = rs_cnt;
    bus_start();
    chk(rs_cnt == r0 + 1 && !last_wrote, "R8 rstart no write", rs_cnt, r0 + 1);
    write_byte(addr_byte(strap, 1'b1), ack);
    chk(ack, "R1 read address ack", ack, 1);
    read_byte(1'b1, v);
    chk(v == exp_mem[8'h10], "R6 read byte", v, exp_mem[8'h10]);
    read_byte(1'b0, v);
    chk(v == exp_mem[8'h10], "R6 second read same pointer", v, exp_mem[8'h10]);
    tick(Q);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    read_bit(b);
    chk(b == 1'b1, "R7 stays released", b, 1);
    s0 = stop_cnt;
    bus_stop();
    chk(stop_cnt == s0 + 1 && !last_wrote, "R8 read stop flag clear", last_wrote, 0);

    // stop mid-byte aborts
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    write_byte(8'h20, ack);
    n0 = wr_cnt;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk(wr_cnt == n0 && mem[8'h20] == exp_mem[8'h20], "R9 partial byte dropped", wr_cnt, n0);
    // start mid-byte aborts
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    write_byte(addr_byte(strap, 1'b0), ack);
    chk(ack, "R9 address after abort", ack, 1);
    chk(reg_ptr == 8'h20, "R9 pointer untouched", reg_ptr, 8'h20);
    bus_stop();

    // randomized write then read back
    for (int it = 0; it < 20; it++) begin
      p = 8'($urandom);
      d = 8'($urandom);
      bus_start();
      write_byte(addr_byte(strap, 1'b0), ack);
      write_byte(p, ack);
      write_byte(d, ack);
      exp_mem[p] = d;
      chk(ack && mem[p] == d, "R5 random write", mem[p], d);
      bus_start();
      chk(last_wrote, "R8 rstart write flag", last_wrote, 1);
      write_byte(addr_byte(strap, 1'b1), ack);
      read_byte(1'b0, v);
      chk(v == exp_mem[p], "R6 random readback", v, exp_mem[p]);
      bus_stop();
    end

    chk(hold_err == 0, "R11 sda stable in scl high", hold_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule